// File: doc/BRIEF.md
# IDE PIO Cycle Sequencer

This block runs one programmed-I/O access at a time on a parallel ATA channel with two attached devices. A host-side request names the device, read or write, and whether the target is the data port or a register. Register accesses also carry a 3-bit address and a control-block select. The sequencer drives the address and chip-select pins and holds them for a programmed setup time. It then pulses the active-low read or write strobe, stretching it while the device holds IORDY low. It holds the address after the strobe for a programmed recovery time and finally pulses a completion flag. Read data is captured as the strobe is released.

Each device has its own timing words for data-port accesses and for register (command-block) accesses. Each word holds setup, active and recovery counts in core clock cycles. A per-device format bit selects how register accesses are timed. They either use the slowest of both devices' data timings, so a register access is safe for both drives, or they use that device's own register timing word. A separate output carries a reset to the drive. It is forced low during system reset and otherwise follows a control input.

Top module: `ide_pio_seq`

## Requirements
- R1: An accepted access passes through three phases in order. Chip select and address are asserted first with both strobes high, then one strobe is low, then chip select stays asserted with both strobes high, then chip select is released.
- R2: The setup phase lasts the effective setup count in cycles, and address and chip select are stable in the cycle before the strobe goes low.
- R3: When the synchronized IORDY is high at the last cycle of the programmed active count, the strobe is low for exactly the effective active count.
- R4: The recovery phase lasts the effective recovery count with address and chip select unchanged. rsp_done is high for exactly one cycle, the first cycle in which chip select is released.
- R5: When the synchronized IORDY is low at the sample point, the strobe stays low. IORDY passes through two flops, so the strobe rises after the third rising clock edge following IORDY going high.
- R6: If IORDY stays low for WAIT_LIMIT (default 255) wait cycles, the strobe is released anyway. rsp_timeout is then high at rsp_done and stays high until the next access is accepted. An access that ends normally leaves rsp_timeout low.
- R7: Each timing word packs setup in bits [3:0], active in [7:4] and recovery in [11:8]. A field of 0 counts as 1 cycle, and each device has its own data and register words.
- R8: Data-port accesses use the selected device's data word. For register accesses, cfg_split bit d = 1 selects device d's register word. When cfg_split bit d = 0, each field is the larger of the two devices' data-word fields.
- R9: A data-port access drives ata_addr = 0 and ata_cs_n = 2'b10. A register access drives ata_addr = req_addr and ata_cs_n = 2'b01 when req_ctl = 1, else 2'b10. Idle drives ata_cs_n = 2'b11. Reads use ata_dior_n and writes use ata_diow_n, never both. Writes drive ata_dd_out = req_wdata with ata_dd_oe high for the whole access.
- R10: rsp_rdata takes ata_dd_in at the clock edge that releases the read strobe and holds it. Write accesses leave rsp_rdata unchanged.
- R11: req_ready is high only when idle. A request presented while busy is ignored and starts no access.
- R12: ata_reset_n is 0 while rst_n is low. Otherwise it equals the inverse of cfg_drive_reset one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request will be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_dev | input | 1 | Target device (0 or 1) |
| req_cmd | input | 1 | 1 = register access, 0 = data port |
| req_ctl | input | 1 | Register access goes to the control block |
| req_addr | input | 3 | Register address |
| req_wdata | input | 16 | Write data |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Last read data |
| rsp_timeout | output | 1 | Last access ended by the IORDY wait limit |
| cfg_data_tim0 | input | 12 | Device 0 data-port timing word |
| cfg_data_tim1 | input | 12 | Device 1 data-port timing word |
| cfg_cmd_tim0 | input | 12 | Device 0 register timing word |
| cfg_cmd_tim1 | input | 12 | Device 1 register timing word |
| cfg_split | input | 2 | Per-device timing format bit |
| cfg_drive_reset | input | 1 | Request reset on the drive |
| ata_addr | output | 3 | Device address pins |
| ata_cs_n | output | 2 | Chip selects: bit 0 command block, bit 1 control block |
| ata_dior_n | output | 1 | Read strobe, active low |
| ata_diow_n | output | 1 | Write strobe, active low |
| ata_dd_out | output | 16 | Data bus out |
| ata_dd_oe | output | 1 | Data bus output enable |
| ata_dd_in | input | 16 | Data bus in |
| ata_iordy | input | 1 | Device ready, asynchronous |
| ata_reset_n | output | 1 | Reset to the drive, active low |

## Verification
On every cycle the assertions check several rules. Address and chip select must be steady when a strobe falls and still held when it rises. The two strobes are never low together, and the idle state drives nothing. The phases follow their order, done is a single-cycle pulse, the wait counter stays below its limit, and the drive reset output follows its control. Only the bench scenarios can show the exact phase lengths for each device, format and zero field. They also cover the three-edge IORDY release latency, the timeout at 255 wait cycles, and read data captured at strobe release rather than later. Random accesses with random timing words are mixed with directed zero, maximum, stretch and timeout cases.

// File: rtl/ide_pio_pkg.sv
package ide_pio_pkg;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_SETUP,
      PH_ACTIVE,
      PH_WAIT,
      PH_RECOVER
   } pio_phase_e;

   localparam int unsigned NUM_FIELDS = 3;
   localparam int unsigned NUM_DEVS   = 2;

endpackage

// File: rtl/ide_pio_sync.sv
module ide_pio_sync #(
   parameter int STAGES    = 2,
   parameter bit RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic sync_out
);

   logic [STAGES-1:0] chain;

   initial begin : stage_param_chk
      assert (STAGES >= 2) else $error("ide_pio_sync: STAGES must be at least 2");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) chain <= {STAGES{RESET_VAL}};
      else        chain <= {chain[STAGES-2:0], async_in};
   end

   assign sync_out = chain[STAGES-1];

endmodule

// File: rtl/ide_pio_tsel.sv
module ide_pio_tsel #(
   parameter int CNT_W = 4
) (
   input  logic [3*CNT_W-1:0] data_tim0,
   input  logic [3*CNT_W-1:0] data_tim1,
   input  logic [3*CNT_W-1:0] cmd_tim0,
   input  logic [3*CNT_W-1:0] cmd_tim1,
   input  logic [1:0]         split,
   input  logic               dev,
   input  logic               cmd,
   output logic [3*CNT_W-1:0] eff
);
   import ide_pio_pkg::*;

   logic use_own_cmd;
   assign use_own_cmd = split[dev];

   for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_field
      logic [CNT_W-1:0] d0, d1, c0, c1, slow, own_d, own_c, pick;
      assign d0    = data_tim0[f*CNT_W +: CNT_W];
      assign d1    = data_tim1[f*CNT_W +: CNT_W];
      assign c0    = cmd_tim0[f*CNT_W +: CNT_W];
      assign c1    = cmd_tim1[f*CNT_W +: CNT_W];
      assign slow  = (d0 > d1) ? d0 : d1;
      assign own_d = dev ? d1 : d0;
      assign own_c = dev ? c1 : c0;
      assign pick  = !cmd ? own_d : (use_own_cmd ? own_c : slow);
      assign eff[f*CNT_W +: CNT_W] = (pick == '0) ? CNT_W'(1) : pick;
   end

endmodule

// File: rtl/ide_pio_ctrl.sv
module ide_pio_ctrl
   import ide_pio_pkg::*;
#(
   parameter int CNT_W      = 4,
   parameter int DATA_W     = 16,
   parameter int ADDR_W     = 3,
   parameter int WAIT_LIMIT = 255
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic               req_write,
   input  logic               req_cmd,
   input  logic               req_ctl,
   input  logic [ADDR_W-1:0]  req_addr,
   input  logic [DATA_W-1:0]  req_wdata,
   input  logic [3*CNT_W-1:0] tim_eff,
   input  logic               iordy_s,
   input  logic [DATA_W-1:0]  dd_in,
   output pio_phase_e         phase,
   output logic               write_q,
   output logic [ADDR_W-1:0]  addr_q,
   output logic [1:0]         cs_n_q,
   output logic [DATA_W-1:0]  wdata_q,
   output logic [DATA_W-1:0]  rdata_q,
   output logic               done_q,
   output logic               timeout_q
);

   localparam int WAIT_W = $clog2(WAIT_LIMIT + 1);

   logic [CNT_W-1:0]  cnt;
   logic [CNT_W-1:0]  act_q;
   logic [CNT_W-1:0]  rec_q;
   logic [WAIT_W-1:0] wcnt;
   logic              last_cnt;
   logic              wait_expired;

   assign last_cnt     = (cnt == CNT_W'(1));
   assign wait_expired = (wcnt == WAIT_W'(WAIT_LIMIT - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase     <= PH_IDLE;
         cnt       <= '0;
         act_q     <= '0;
         rec_q     <= '0;
         wcnt      <= '0;
         write_q   <= 1'b0;
         addr_q    <= '0;
         cs_n_q    <= 2'b11;
         wdata_q   <= '0;
         rdata_q   <= '0;
         done_q    <= 1'b0;
         timeout_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (phase)
            PH_IDLE: begin
               if (start) begin
                  phase     <= PH_SETUP;
                  cnt       <= tim_eff[0 +: CNT_W];
                  act_q     <= tim_eff[CNT_W +: CNT_W];
                  rec_q     <= tim_eff[2*CNT_W +: CNT_W];
                  write_q   <= req_write;
                  addr_q    <= req_cmd ? req_addr : '0;
                  cs_n_q    <= (req_cmd && req_ctl) ? 2'b01 : 2'b10;
                  wdata_q   <= req_wdata;
                  timeout_q <= 1'b0;
               end
            end
            PH_SETUP: begin
               if (last_cnt) begin
                  phase <= PH_ACTIVE;
                  cnt   <= act_q;
               end else begin
                  cnt <= cnt - CNT_W'(1);
               end
            end
            PH_ACTIVE: begin
               if (!last_cnt) begin
                  cnt <= cnt - CNT_W'(1);
               end else if (iordy_s) begin
                  phase <= PH_RECOVER;
                  cnt   <= rec_q;
                  if (!write_q) rdata_q <= dd_in;
               end else begin
                  phase <= PH_WAIT;
                  wcnt  <= '0;
               end
            end
            PH_WAIT: begin
               if (iordy_s || wait_expired) begin
                  phase     <= PH_RECOVER;
                  cnt       <= rec_q;
                  timeout_q <= !iordy_s;
                  if (!write_q) rdata_q <= dd_in;
               end else begin
                  wcnt <= wcnt + WAIT_W'(1);
               end
            end
            PH_RECOVER: begin
               if (last_cnt) begin
                  phase  <= PH_IDLE;
                  done_q <= 1'b1;
               end else begin
                  cnt <= cnt - CNT_W'(1);
               end
            end
            default: phase <= PH_IDLE;
         endcase
      end
   end

   // R6
   wait_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_WAIT) |-> (wcnt < WAIT_W'(WAIT_LIMIT)));

   // R4
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q);

   // R1
   phase_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_SETUP) |=> (phase == PH_SETUP || phase == PH_ACTIVE));

   // R5
   wait_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_WAIT && iordy_s) |=> (phase == PH_RECOVER));

endmodule

// File: rtl/ide_pio_seq.sv
module ide_pio_seq
   import ide_pio_pkg::*;
#(
   parameter int CNT_W       = 4,
   parameter int DATA_W      = 16,
   parameter int ADDR_W      = 3,
   parameter int WAIT_LIMIT  = 255,
   parameter int SYNC_STAGES = 2,
   localparam int TIM_W      = 3 * CNT_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic              req_dev,
   input  logic              req_cmd,
   input  logic              req_ctl,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rsp_done,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              rsp_timeout,
   input  logic [TIM_W-1:0]  cfg_data_tim0,
   input  logic [TIM_W-1:0]  cfg_data_tim1,
   input  logic [TIM_W-1:0]  cfg_cmd_tim0,
   input  logic [TIM_W-1:0]  cfg_cmd_tim1,
   input  logic [1:0]        cfg_split,
   input  logic              cfg_drive_reset,
   output logic [ADDR_W-1:0] ata_addr,
   output logic [1:0]        ata_cs_n,
   output logic              ata_dior_n,
   output logic              ata_diow_n,
   output logic [DATA_W-1:0] ata_dd_out,
   output logic              ata_dd_oe,
   input  logic [DATA_W-1:0] ata_dd_in,
   input  logic              ata_iordy,
   output logic              ata_reset_n
);

   initial begin : seq_param_chk
      assert (CNT_W >= 2 && CNT_W <= 8) else $error("ide_pio_seq: CNT_W out of range");
      assert (WAIT_LIMIT >= 2) else $error("ide_pio_seq: WAIT_LIMIT too small");
      assert (DATA_W >= 8) else $error("ide_pio_seq: DATA_W too small");
      assert (ADDR_W >= 1) else $error("ide_pio_seq: ADDR_W too small");
   end

   pio_phase_e        phase;
   logic              write_q;
   logic [TIM_W-1:0]  tim_eff;
   logic              iordy_s;
   logic              strobe_int;
   logic              strobe_on;
   logic              drv_rst_n_q;

   ide_pio_tsel #(.CNT_W(CNT_W)) u_tsel (
      .data_tim0 (cfg_data_tim0),
      .data_tim1 (cfg_data_tim1),
      .cmd_tim0  (cfg_cmd_tim0),
      .cmd_tim1  (cfg_cmd_tim1),
      .split     (cfg_split),
      .dev       (req_dev),
      .cmd       (req_cmd),
      .eff       (tim_eff)
   );

   ide_pio_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_iordy_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (ata_iordy),
      .sync_out (iordy_s)
   );

   ide_pio_ctrl #(
      .CNT_W      (CNT_W),
      .DATA_W     (DATA_W),
      .ADDR_W     (ADDR_W),
      .WAIT_LIMIT (WAIT_LIMIT)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (req_valid),
      .req_write (req_write),
      .req_cmd   (req_cmd),
      .req_ctl   (req_ctl),
      .req_addr  (req_addr),
      .req_wdata (req_wdata),
      .tim_eff   (tim_eff),
      .iordy_s   (iordy_s),
      .dd_in     (ata_dd_in),
      .phase     (phase),
      .write_q   (write_q),
      .addr_q    (ata_addr),
      .cs_n_q    (u_cs_n_q),
      .wdata_q   (ata_dd_out),
      .rdata_q   (rsp_rdata),
      .done_q    (rsp_done),
      .timeout_q (rsp_timeout)
   );

   logic [1:0] u_cs_n_q;

   always_ff @(posedge clk) begin
      if (!rst_n) drv_rst_n_q <= 1'b0;
      else        drv_rst_n_q <= !cfg_drive_reset;
   end

   assign strobe_int  = (phase == PH_ACTIVE) || (phase == PH_WAIT);
   assign req_ready   = (phase == PH_IDLE);
   assign ata_cs_n    = (phase == PH_IDLE) ? 2'b11 : u_cs_n_q;
   assign ata_dior_n  = !(strobe_int && !write_q);
   assign ata_diow_n  = !(strobe_int && write_q);
   assign ata_dd_oe   = write_q && (phase != PH_IDLE);
   assign ata_reset_n = drv_rst_n_q;

   assign strobe_on = !ata_dior_n || !ata_diow_n;

   // R2
   setup_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(strobe_on) |-> ($stable(ata_addr) && $stable(ata_cs_n) && ata_cs_n != 2'b11));

   // R4
   recovery_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(strobe_on) |-> ($stable(ata_addr) && ata_cs_n != 2'b11));

   // R9
   strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(!ata_dior_n && !ata_diow_n));

   // R11
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (!strobe_on && ata_cs_n == 2'b11 && !ata_dd_oe));

   // R12
   drive_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (ata_reset_n == !$past(cfg_drive_reset)));

endmodule

// File: tb/ide_pio_seq_test.sv
module ide_pio_seq_test;

   localparam int WAITS = 255;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic        req_write = 1'b0;
   logic        req_dev = 1'b0;
   logic        req_cmd = 1'b0;
   logic        req_ctl = 1'b0;
   logic [2:0]  req_addr = '0;
   logic [15:0] req_wdata = '0;
   logic        rsp_done;
   logic [15:0] rsp_rdata;
   logic        rsp_timeout;
   logic [11:0] dt0 = '0, dt1 = '0, ct0 = '0, ct1 = '0;
   logic [1:0]  split = '0;
   logic        drv_rst = 1'b0;
   logic [2:0]  ata_addr;
   logic [1:0]  ata_cs_n;
   logic        ata_dior_n, ata_diow_n, ata_dd_oe, ata_reset_n;
   logic [15:0] ata_dd_out;
   logic [15:0] dd_in = '0;
   logic        iordy = 1'b1;

   int checks = 0;
   int errors = 0;
   logic [15:0] last_read = '0;

   always #5 clk = ~clk;

   ide_pio_seq uut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
      .req_dev(req_dev), .req_cmd(req_cmd), .req_ctl(req_ctl),
      .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .rsp_timeout(rsp_timeout),
      .cfg_data_tim0(dt0), .cfg_data_tim1(dt1), .cfg_cmd_tim0(ct0), .cfg_cmd_tim1(ct1),
      .cfg_split(split), .cfg_drive_reset(drv_rst),
      .ata_addr(ata_addr), .ata_cs_n(ata_cs_n), .ata_dior_n(ata_dior_n),
      .ata_diow_n(ata_diow_n), .ata_dd_out(ata_dd_out), .ata_dd_oe(ata_dd_oe),
      .ata_dd_in(dd_in), .ata_iordy(iordy), .ata_reset_n(ata_reset_n)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int unsigned eff(input int unsigned v);
      return (v == 0) ? 1 : v;
   endfunction

   // field 0 setup, 1 active, 2 recovery (R7); format selection (R8)
   function automatic int unsigned exp_len(input bit dev, input bit cmd, input int f);
      int unsigned d0, d1, c0, c1;
      d0 = dt0[f*4 +: 4]; d1 = dt1[f*4 +: 4];
      c0 = ct0[f*4 +: 4]; c1 = ct1[f*4 +: 4];
      if (!cmd) return eff(dev ? d1 : d0);
      if (split[dev]) return eff(dev ? c1 : c0);
      return eff((d0 > d1) ? d0 : d1);
   endfunction

   // mode 0: IORDY high, 1: IORDY low then raised after extra, 2: IORDY stuck low
   task automatic run_access(input bit wr, input bit dev, input bit cmd, input bit ctl,
                             input logic [2:0] addr, input logic [15:0] wd,
                             input int mode, input int extra);
      int su = 0, st = 0, rc = 0, phase = 0, k;
      bit ended = 0;
      logic [2:0]  e_addr;
      logic [1:0]  e_cs;
      logic [15:0] rd_val;
      int e_su, e_act, e_rec, e_st;
      e_su  = exp_len(dev, cmd, 0);
      e_act = exp_len(dev, cmd, 1);
      e_rec = exp_len(dev, cmd, 2);
      k     = e_act + extra;
      e_st  = (mode == 0) ? e_act : (mode == 1) ? k + 2 : e_act + WAITS;
      e_addr = cmd ? addr : 3'd0;
      e_cs   = (cmd && ctl) ? 2'b01 : 2'b10;
      rd_val = 16'($urandom);
      if (mode != 0) begin
         @(negedge clk); iordy = 1'b0;
         repeat (3) @(negedge clk);
      end
      @(negedge clk);
      check(req_ready == 1'b1, "R11 ready when idle", int'(req_ready), 1);
      req_valid = 1'b1; req_write = wr; req_dev = dev; req_cmd = cmd;
      req_ctl = ctl; req_addr = addr; req_wdata = wd; dd_in = rd_val;
      for (int n = 1; n < 400 && !ended; n++) begin
         bit lo;
         @(negedge clk);
         if (n == 1) begin
            check(req_ready == 1'b0, "R11 busy not ready", int'(req_ready), 0);
            req_valid = 1'b1; req_addr = ~addr; req_write = ~wr; req_cmd = 1'b1;
         end else if (n == 2) begin
            req_valid = 1'b0;
         end
         if (ata_cs_n == 2'b11) begin
            ended = 1;
         end else begin
            if (ata_addr != e_addr || ata_cs_n != e_cs) begin
               check(0, "R9 address/select", int'({ata_cs_n, ata_addr}), int'({e_cs, e_addr}));
            end
            if ((wr ? ata_dior_n : ata_diow_n) == 1'b0)
               check(0, "R9 wrong strobe", 0, 1);
            if (ata_dd_oe != wr || (wr && ata_dd_out != wd))
               check(0, "R9 write drive", int'(ata_dd_out), int'(wd));
            if (rsp_done) check(0, "R4 done early", 1, 0);
            lo = wr ? !ata_diow_n : !ata_dior_n;
            if (phase == 0) begin
               if (lo) begin phase = 1; st++; end else su++;
            end else if (phase == 1) begin
               if (lo) st++;
               else begin phase = 2; rc++; dd_in = ~rd_val; end
            end else begin
               if (lo) check(0, "R1 strobe after recovery", 1, 0);
               rc++;
            end
            if (phase == 1 && mode == 1 && st == k) iordy = 1'b1;
         end
      end
      check(ended, "R1 access completes", int'(ended), 1);
      check(su == e_su, "R2 setup cycles", su, e_su);
      if (mode == 0)      check(st == e_st, "R3 active cycles", st, e_st);
      else if (mode == 1) check(st == e_st, "R5 stretched strobe", st, e_st);
      else                check(st == e_st, "R6 timeout strobe", st, e_st);
      check(rc == e_rec, "R4 recovery cycles", rc, e_rec);
      check(rsp_done == 1'b1, "R4 done with release", int'(rsp_done), 1);
      check(rsp_timeout == (mode == 2), "R6 timeout flag", int'(rsp_timeout), int'(mode == 2));
      if (!wr) last_read = rd_val;
      check(rsp_rdata == last_read, "R10 read data", int'(rsp_rdata), int'(last_read));
      @(negedge clk);
      check(rsp_done == 1'b0, "R4 done one cycle", int'(rsp_done), 0);
      check(ata_cs_n == 2'b11, "R11 busy request ignored", int'(ata_cs_n), 3);
      iordy = 1'b1;
      repeat (3) @(negedge clk);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : main
      int unsigned seed;
      seed = $urandom(32'h5eed_1de5);
      repeat (3) @(negedge clk);
      check(ata_reset_n == 1'b0, "R12 drive reset in system reset", int'(ata_reset_n), 0);
      check(req_ready == 1'b1 && ata_cs_n == 2'b11 && ata_dior_n && ata_diow_n,
            "R1 reset idle", int'(ata_cs_n), 3);
      check(rsp_done == 1'b0 && rsp_timeout == 1'b0, "R4 reset outputs", int'(rsp_done), 0);
      rst_n = 1'b1;
      @(negedge clk); @(negedge clk);
      check(ata_reset_n == 1'b1, "R12 drive reset released", int'(ata_reset_n), 1);
      drv_rst = 1'b1; @(negedge clk);
      check(ata_reset_n == 1'b0, "R12 drive reset follows control", int'(ata_reset_n), 0);
      drv_rst = 1'b0; @(negedge clk);
      check(ata_reset_n == 1'b1, "R12 drive reset cleared", int'(ata_reset_n), 1);

      // R7 zero fields act as one cycle
      dt0 = 12'h000; dt1 = 12'h000; ct0 = 12'h000; ct1 = 12'h000; split = 2'b00;
      run_access(1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 16'h0, 0, 0);
      run_access(1'b1, 1'b1, 1'b1, 1'b1, 3'd6, 16'h00a5, 0, 0);
      // R7 maximum fields
      dt0 = 12'hfff; run_access(1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 16'h0, 0, 0);
      // R8 format 0: command on fast device takes slow device timing
      dt0 = 12'h111; dt1 = 12'h9c5; ct0 = 12'h222; ct1 = 12'h333; split = 2'b00;
      run_access(1'b0, 1'b0, 1'b1, 1'b0, 3'd7, 16'h0, 0, 0);
      run_access(1'b0, 1'b0, 1'b0, 1'b0, 3'd3, 16'h0, 0, 0);
      // R8 format 1: own command timing
      split = 2'b01;
      run_access(1'b1, 1'b0, 1'b1, 1'b0, 3'd2, 16'h1234, 0, 0);
      run_access(1'b1, 1'b1, 1'b1, 1'b0, 3'd5, 16'h4321, 0, 0);
      // R10 writes keep read data
      run_access(1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 16'hbeef, 0, 0);
      // R5 stretch at sample point and later
      run_access(1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 16'h0, 1, 0);
      run_access(1'b0, 1'b1, 1'b0, 1'b0, 3'd0, 16'h0, 1, 7);
      // R6 timeout then normal clears flag
      run_access(1'b0, 1'b1, 1'b1, 1'b0, 3'd1, 16'h0, 2, 0);
      run_access(1'b1, 1'b0, 1'b1, 1'b1, 3'd6, 16'h0f0f, 0, 0);

      for (int i = 0; i < 40; i++) begin
         int m;
         dt0 = 12'($urandom); dt1 = 12'($urandom);
         ct0 = 12'($urandom); ct1 = 12'($urandom);
         split = 2'($urandom);
         m = ($urandom % 4 == 0) ? 1 : 0;
         run_access(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                    3'($urandom), 16'($urandom), m, int'($urandom % 6));
      end

      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule